// File: doc/BRIEF.md
# Event Counter Bank with Memory-Mapped Registers

This block holds a parameterised bank of event counters behind a simple register port (address, write strobe, write data, combinational read data). Each counter counts pulses on its own event input while the bank is running and the counter is enabled. A counter that passes its all-ones value returns to zero and latches an overflow flag. An overflow flag whose interrupt enable is set drives a level interrupt, provided the interrupt output is switched on. Software can preload any counter, for example to half of full scale, so that an overflow arrives after a chosen number of events.

Three 64-bit bitmaps hold the per-counter state: counter enable, interrupt enable and overflow. Each bitmap has one address where writing ones sets bits and another where writing ones clears them. Both addresses read back the current bitmap. A read-only configuration word reports the counter count and width. A fixed 128-bit mask, read as two words, lists the supported event IDs. Per-counter event-type and stream-match registers are plain storage for the owning software and have no effect on counting.

Run control is a two-state machine. In HALTED, no counter moves. The START transition, a control write with bit 0 set while halted, enters COUNTING. The STOP transition, a control write with bit 0 clear while counting, returns to HALTED. Every other cycle keeps the current state.

Top module: `evtctr_bank`

## Requirements
- R1: The configuration word at 0xE00 returns NUM_CTR-1 in bits 5:0, CTR_W-1 in bits 13:8, zero in bit 20 (counters share the register page) and bit 21 (no message interrupts), and GLOBAL_FILT in bit 23. The supported-event mask returns its bits 63:0 at 0xE20 and its bits 127:64 at 0xE28.
- R2: Reset clears the state machine to HALTED and clears all counters, all three bitmaps, the interrupt output enable and the event-type and stream-match registers.
- R3: Counter n is read and written at n×8 when CTR_W exceeds 32, and at n×4 otherwise. A read returns the value zero-extended. A write loads wdata[CTR_W-1:0]. Unmapped addresses read zero.
- R4: A counter adds one at a clock edge where the bank is COUNTING, its enable bit is set and its event input is high. Otherwise it holds.
- R5: Writing ones at 0xC00 sets counter-enable bits and writing ones at 0xC20 clears them. Zero bits leave state alone, and both addresses read back the enable bitmap.
- R6: Writing ones at 0xC40 sets interrupt-enable bits and writing ones at 0xC60 clears them. Both addresses read back the bitmap.
- R7: Writing ones at 0xCC0 sets overflow bits and writing ones at 0xC80 clears them. Both addresses read back the bitmap. A hardware overflow in the same cycle as a clear of that bit leaves the bit set.
- R8: An increment from all ones gives zero and sets that counter's overflow bit at the same clock edge.
- R9: A write to a counter in the same cycle as its increment loads the written value, and the increment is lost.
- R10: Bit 0 of the control word at 0xE04 selects the state: a write of 1 enters COUNTING and a write of 0 enters HALTED. A read returns 1 in bit 0 while COUNTING.
- R11: irq is high exactly when bit 0 of 0xE50 is set and some counter has both its overflow bit and its interrupt-enable bit set.
- R12: The event-type register n at 0x400+4n keeps the low ETYPE_W bits written. The stream-match register n at 0xA00+4n keeps MATCH_W bits. Both read back and do not affect counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| cnt_evt | input | NUM_CTR | Per-counter event input, one count per high cycle |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties take for granted several things about the inputs. Addresses are aligned to the register stride. A write lasts a single cycle. Event inputs are synchronous to clk and count at most once per cycle. The stimulus uses only aligned offsets and holds bus_wr and cnt_evt high for exactly one cycle per operation. All inputs change on the falling edge, so every property sees settled values at the rising edge. The two same-cycle collisions, a counter write against an increment and an overflow clear against a wrap, are driven as deliberate single-cycle overlaps.

// File: rtl/ctrbank_pkg.sv
package ctrbank_pkg;

    localparam int BUS_W  = 64;
    localparam int ADDR_W = 12;

    typedef enum logic [0:0] {
        ST_HALTED   = 1'b0,
        ST_COUNTING = 1'b1
    } run_state_e;

    localparam logic [ADDR_W-1:0] OFS_EN_SET     = 12'hC00;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR     = 12'hC20;
    localparam logic [ADDR_W-1:0] OFS_IE_SET     = 12'hC40;
    localparam logic [ADDR_W-1:0] OFS_IE_CLR     = 12'hC60;
    localparam logic [ADDR_W-1:0] OFS_OV_CLR     = 12'hC80;
    localparam logic [ADDR_W-1:0] OFS_OV_SET     = 12'hCC0;
    localparam logic [ADDR_W-1:0] OFS_CFG        = 12'hE00;
    localparam logic [ADDR_W-1:0] OFS_CTRL       = 12'hE04;
    localparam logic [ADDR_W-1:0] OFS_SUP_LO     = 12'hE20;
    localparam logic [ADDR_W-1:0] OFS_SUP_HI     = 12'hE28;
    localparam logic [ADDR_W-1:0] OFS_IRQ_CTL    = 12'hE50;
    localparam logic [ADDR_W-1:0] OFS_ETYPE_BASE = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_MATCH_BASE = 12'hA00;

endpackage

// File: rtl/ctr_slice.sv
module ctr_slice #(
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ld,
    input  logic [CTR_W-1:0] ld_val,
    output logic [CTR_W-1:0] value,
    output logic             wrap
);

    // A load takes precedence over a pending increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (ld)  value <= ld_val;
        else if (inc) value <= value + 1'b1;
    end

    // Overflow flag is raised at the edge where the count returns to zero
    assign wrap = inc && !ld && (&value);

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (value == $past(ld_val)));

    assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && (&value)) |=> (value == '0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !ld) |=> $stable(value));

endmodule

// File: rtl/bitmap_w1.sv
module bitmap_w1 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] bits
);

    // Set beats clear so that a hardware event is never lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits <= '0;
        else        bits <= (bits & ~clr_mask) | set_mask;
    end

    // Used for the enable (R5), interrupt-enable (R6) and overflow bitmaps
    assert_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((bits & $past(set_mask)) == $past(set_mask)));

    assert_clear_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask != '0) && (set_mask == '0)) |=> ((bits & $past(clr_mask)) == '0));

endmodule

// File: rtl/run_ctrl.sv
module run_ctrl
    import ctrbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_bit,
    output logic run
);

    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED:   if (ctl_wr && ctl_bit)  state_d = ST_COUNTING; // START
            ST_COUNTING: if (ctl_wr && !ctl_bit) state_d = ST_HALTED;   // STOP
            default:     state_d = ST_HALTED;
        endcase
    end

    always_comb begin
        run = (state_q == ST_COUNTING);
    end

    assert_stay_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HALTED) && !(ctl_wr && ctl_bit)) |=> (state_q == ST_HALTED));

    assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_bit) |=> run);

    assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_bit) |=> !run);

endmodule

// File: rtl/evtctr_bank.sv
module evtctr_bank
    import ctrbank_pkg::*;
#(
    parameter int           NUM_CTR     = 8,
    parameter int           CTR_W       = 32,
    parameter int           ETYPE_W     = 16,
    parameter int           MATCH_W     = 32,
    parameter bit           GLOBAL_FILT = 1'b0,
    parameter logic [127:0] SUP_EVENTS  = 128'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        bus_addr,
    input  logic               bus_wr,
    input  logic [63:0]        bus_wdata,
    output logic [63:0]        bus_rdata,
    input  logic [NUM_CTR-1:0] cnt_evt,
    output logic               irq
);

    localparam int STRIDE = (CTR_W > 32) ? 8 : 4;

    logic [NUM_CTR-1:0] en_bits, ie_bits, ov_bits;
    logic [NUM_CTR-1:0] en_set, en_clr, ie_set, ie_clr, ov_set, ov_clr;
    logic [NUM_CTR-1:0] ctr_hit, ety_hit, mat_hit, inc_vec, wrap_vec;
    logic [CTR_W-1:0]   ctr_val [NUM_CTR];
    logic [ETYPE_W-1:0] ety_q   [NUM_CTR];
    logic [MATCH_W-1:0] mat_q   [NUM_CTR];
    logic               run, irq_en_q;
    logic [BUS_W-1:0]   fixed_rd, arr_rd;
    logic [31:0]        cfg_word;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata;

    function automatic logic wr_at(input logic [ADDR_W-1:0] ofs);
        return bus_wr && (bus_addr == ofs);
    endfunction

    // Run-control state machine
    run_ctrl u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (wr_at(OFS_CTRL)),
        .ctl_bit (bus_wdata[0]),
        .run     (run)
    );

    // Set/clear bitmaps
    assign en_set = wr_at(OFS_EN_SET) ? bus_wdata[NUM_CTR-1:0] : '0;
    assign en_clr = wr_at(OFS_EN_CLR) ? bus_wdata[NUM_CTR-1:0] : '0;
    assign ie_set = wr_at(OFS_IE_SET) ? bus_wdata[NUM_CTR-1:0] : '0;
    assign ie_clr = wr_at(OFS_IE_CLR) ? bus_wdata[NUM_CTR-1:0] : '0;
    assign ov_set = (wr_at(OFS_OV_SET) ? bus_wdata[NUM_CTR-1:0] : '0) | wrap_vec;
    assign ov_clr = wr_at(OFS_OV_CLR) ? bus_wdata[NUM_CTR-1:0] : '0;

    bitmap_w1 #(.W(NUM_CTR)) u_en (
        .clk(clk), .rst_n(rst_n), .set_mask(en_set), .clr_mask(en_clr), .bits(en_bits));
    bitmap_w1 #(.W(NUM_CTR)) u_ie (
        .clk(clk), .rst_n(rst_n), .set_mask(ie_set), .clr_mask(ie_clr), .bits(ie_bits));
    bitmap_w1 #(.W(NUM_CTR)) u_ov (
        .clk(clk), .rst_n(rst_n), .set_mask(ov_set), .clr_mask(ov_clr), .bits(ov_bits));

    // Per-counter structure
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        assign ctr_hit[n] = (bus_addr == ADDR_W'(n * STRIDE));
        assign ety_hit[n] = (bus_addr == ADDR_W'(int'(OFS_ETYPE_BASE) + 4 * n));
        assign mat_hit[n] = (bus_addr == ADDR_W'(int'(OFS_MATCH_BASE) + 4 * n));
        assign inc_vec[n] = run && en_bits[n] && cnt_evt[n];

        ctr_slice #(.CTR_W(CTR_W)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc_vec[n]),
            .ld     (bus_wr && ctr_hit[n]),
            .ld_val (bus_wdata[CTR_W-1:0]),
            .value  (ctr_val[n]),
            .wrap   (wrap_vec[n])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ety_q[n] <= '0;
                mat_q[n] <= '0;
            end else if (bus_wr) begin
                if (ety_hit[n]) ety_q[n] <= bus_wdata[ETYPE_W-1:0];
                if (mat_hit[n]) mat_q[n] <= bus_wdata[MATCH_W-1:0];
            end
        end
    end

    // Interrupt output enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               irq_en_q <= 1'b0;
        else if (wr_at(OFS_IRQ_CTL)) irq_en_q <= bus_wdata[0];
    end

    assign irq = irq_en_q && ((ov_bits & ie_bits) != '0);

    // Read path
    assign cfg_word = {8'h00, GLOBAL_FILT, 1'b0, 1'b0, 1'b0, 6'h00,
                       6'(CTR_W - 1), 2'b00, 6'(NUM_CTR - 1)};

    always_comb begin
        fixed_rd = '0;
        case (bus_addr)
            OFS_EN_SET, OFS_EN_CLR: fixed_rd = BUS_W'(en_bits);
            OFS_IE_SET, OFS_IE_CLR: fixed_rd = BUS_W'(ie_bits);
            OFS_OV_SET, OFS_OV_CLR: fixed_rd = BUS_W'(ov_bits);
            OFS_CFG:                fixed_rd = BUS_W'(cfg_word);
            OFS_CTRL:               fixed_rd = BUS_W'(run);
            OFS_IRQ_CTL:            fixed_rd = BUS_W'(irq_en_q);
            OFS_SUP_LO:             fixed_rd = SUP_EVENTS[63:0];
            OFS_SUP_HI:             fixed_rd = SUP_EVENTS[127:64];
            default:                fixed_rd = '0;
        endcase
    end

    always_comb begin
        arr_rd = '0;
        for (int n = 0; n < NUM_CTR; n++) begin
            if (ctr_hit[n]) arr_rd = arr_rd | BUS_W'(ctr_val[n]);
            if (ety_hit[n]) arr_rd = arr_rd | BUS_W'(ety_q[n]);
            if (mat_hit[n]) arr_rd = arr_rd | BUS_W'(mat_q[n]);
        end
    end

    assign bus_rdata = fixed_rd | arr_rd;

    assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_bits == '0) |-> !irq);

    assert_halted_no_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (inc_vec == '0));

    assert_wrap_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_vec != '0) |=> ((ov_bits & $past(wrap_vec)) == $past(wrap_vec)));

endmodule

// File: tb/evtctr_bank_tb_top.sv
`timescale 1ns/1ps
module evtctr_bank_tb_top;

    localparam int NUM_CTR = 4;
    localparam int CTR_W   = 8;

    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_TK = 2'd2, OP_IQ = 2'd3;
    localparam int NV = 57;

    // {op, req, addr, data, expected}
    localparam logic [145:0] VEC [NV] = '{
        {OP_RD, 4'd1,  12'hE00, 64'h0, 64'h0703},          // R1 config word
        {OP_RD, 4'd1,  12'hE20, 64'h0, 64'hFF},            // R1 supported low
        {OP_RD, 4'd1,  12'hE28, 64'h0, 64'h1},             // R1 supported high
        {OP_RD, 4'd2,  12'hC00, 64'h0, 64'h0},             // R2 enables zero
        {OP_RD, 4'd2,  12'h000, 64'h0, 64'h0},             // R2 counter zero
        {OP_WR, 4'd5,  12'hC00, 64'h5, 64'h0},             // R5 set enables 0,2
        {OP_RD, 4'd5,  12'hC20, 64'h0, 64'h5},             // R5 clear alias reads
        {OP_TK, 4'd4,  12'h000, 64'hF, 64'h0},
        {OP_RD, 4'd4,  12'h000, 64'h0, 64'h0},             // R4 halted: no count
        {OP_WR, 4'd10, 12'hE04, 64'h1, 64'h0},             // R10 START
        {OP_RD, 4'd10, 12'hE04, 64'h0, 64'h1},
        {OP_TK, 4'd4,  12'h000, 64'hF, 64'h0},
        {OP_TK, 4'd4,  12'h000, 64'hF, 64'h0},
        {OP_TK, 4'd4,  12'h000, 64'h3, 64'h0},
        {OP_RD, 4'd4,  12'h000, 64'h0, 64'h3},             // R4
        {OP_RD, 4'd4,  12'h004, 64'h0, 64'h0},             // R4 not enabled
        {OP_RD, 4'd4,  12'h008, 64'h0, 64'h2},             // R4
        {OP_WR, 4'd5,  12'hC20, 64'h1, 64'h0},             // R5 clear enable 0
        {OP_RD, 4'd5,  12'hC00, 64'h0, 64'h4},
        {OP_TK, 4'd5,  12'h000, 64'hF, 64'h0},
        {OP_RD, 4'd5,  12'h000, 64'h0, 64'h3},             // R5 cleared one holds
        {OP_RD, 4'd4,  12'h008, 64'h0, 64'h3},
        {OP_WR, 4'd3,  12'h008, 64'h1FE, 64'h0},           // R3 preload, upper bits dropped
        {OP_RD, 4'd3,  12'h008, 64'h0, 64'hFE},
        {OP_TK, 4'd8,  12'h000, 64'h4, 64'h0},
        {OP_RD, 4'd8,  12'h008, 64'h0, 64'hFF},            // R8
        {OP_RD, 4'd8,  12'hCC0, 64'h0, 64'h0},
        {OP_TK, 4'd8,  12'h000, 64'h4, 64'h0},
        {OP_RD, 4'd8,  12'h008, 64'h0, 64'h0},             // R8 wrap to zero
        {OP_RD, 4'd8,  12'hCC0, 64'h0, 64'h4},             // R8 flag same edge
        {OP_IQ, 4'd11, 12'h000, 64'h0, 64'h0},             // R11 no ie
        {OP_WR, 4'd6,  12'hC40, 64'h4, 64'h0},             // R6
        {OP_RD, 4'd6,  12'hC60, 64'h0, 64'h4},
        {OP_IQ, 4'd11, 12'h000, 64'h0, 64'h0},             // R11 output off
        {OP_WR, 4'd11, 12'hE50, 64'h1, 64'h0},
        {OP_IQ, 4'd11, 12'h000, 64'h0, 64'h1},             // R11 raised
        {OP_WR, 4'd7,  12'hC80, 64'h4, 64'h0},             // R7 clear overflow
        {OP_RD, 4'd7,  12'hCC0, 64'h0, 64'h0},
        {OP_IQ, 4'd11, 12'h000, 64'h0, 64'h0},
        {OP_WR, 4'd7,  12'hCC0, 64'h2, 64'h0},             // R7 software set
        {OP_RD, 4'd7,  12'hC80, 64'h0, 64'h2},
        {OP_IQ, 4'd11, 12'h000, 64'h0, 64'h0},             // R11 ie1 off
        {OP_WR, 4'd6,  12'hC40, 64'h2, 64'h0},
        {OP_IQ, 4'd11, 12'h000, 64'h0, 64'h1},
        {OP_WR, 4'd6,  12'hC60, 64'h2, 64'h0},             // R6 clear
        {OP_RD, 4'd6,  12'hC40, 64'h0, 64'h4},
        {OP_IQ, 4'd11, 12'h000, 64'h0, 64'h0},
        {OP_WR, 4'd12, 12'h404, 64'hFFFF_ABCD_1234, 64'h0}, // R12
        {OP_RD, 4'd12, 12'h404, 64'h0, 64'h1234},
        {OP_WR, 4'd12, 12'hA0C, 64'hDEAD_BEEF, 64'h0},
        {OP_RD, 4'd12, 12'hA0C, 64'h0, 64'hDEAD_BEEF},
        {OP_RD, 4'd12, 12'h000, 64'h0, 64'h3},
        {OP_WR, 4'd10, 12'hE04, 64'h0, 64'h0},             // R10 STOP
        {OP_RD, 4'd10, 12'hE04, 64'h0, 64'h0},
        {OP_TK, 4'd10, 12'h000, 64'h4, 64'h0},
        {OP_RD, 4'd10, 12'h008, 64'h0, 64'h0},
        {OP_RD, 4'd3,  12'h010, 64'h0, 64'h0}              // R3 unmapped
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic               bus_wr = 1'b0;
    logic [63:0]        bus_wdata = '0;
    logic [63:0]        bus_rdata;
    logic [NUM_CTR-1:0] cnt_evt = '0;
    logic               irq;
    int                 nchk = 0;
    int                 nfail = 0;

    always #10 clk = ~clk;

    evtctr_bank #(
        .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .SUP_EVENTS({64'h1, 64'hFF})
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_evt(cnt_evt), .irq(irq)
    );

    task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [63:0] d, input logic [NUM_CTR-1:0] e);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; cnt_evt = e;
        @(negedge clk);
        bus_wr = 1'b0; cnt_evt = '0;
    endtask

    task automatic do_tick(input logic [NUM_CTR-1:0] e);
        @(negedge clk);
        cnt_evt = e;
        @(negedge clk);
        cnt_evt = '0;
    endtask

    task automatic do_rd(input int req, input logic [11:0] a, input logic [63:0] exp);
        @(negedge clk);
        bus_addr = a;
        #2;
        check(req, bus_rdata, exp);
    endtask

    task automatic chk_irq(input int req, input logic exp);
        @(negedge clk);
        #2;
        check(req, {63'h0, irq}, {63'h0, exp});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [145:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            case (v[145:144])
                OP_RD: do_rd(int'(v[143:140]), v[139:128], v[63:0]);
                OP_WR: do_wr(v[139:128], v[127:64], '0);
                OP_TK: do_tick(v[64+NUM_CTR-1:64]);
                default: chk_irq(int'(v[143:140]), v[0]);
            endcase
        end

        // R9: counter write and increment in the same cycle
        do_wr(12'hE04, 64'h1, '0);
        do_wr(12'h008, 64'h10, 4'h4);
        do_rd(9, 12'h008, 64'h10);   // R9

        // R7: wrap and overflow clear collide; overflow bit 1 still set from table
        do_wr(12'h008, 64'hFF, '0);
        do_wr(12'hC80, 64'h4, 4'h4);
        do_rd(7, 12'hCC0, 64'h6);    // R7 set wins
        do_rd(8, 12'h008, 64'h0);    // R8

        // R2: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_rd(2, 12'hE04, 64'h0);    // R2 halted
        do_rd(2, 12'hC00, 64'h0);
        do_rd(2, 12'hC40, 64'h0);
        do_rd(2, 12'hCC0, 64'h0);
        do_rd(2, 12'h000, 64'h0);
        do_rd(2, 12'h404, 64'h0);
        do_rd(2, 12'hE50, 64'h0);
        chk_irq(2, 1'b0);            // R2

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule